// File: doc/BRIEF.md
# Sample Clock Phase Tuning Controller

This controller finds a working receive sample-clock phase for a high-speed card interface. After a `start` pulse it steps the sample phase through a set of equally spaced candidates, from index 0 upward. For each candidate it asks an external command engine to run one tuning trial through a request/done handshake. It judges every trial as pass or fail, and tracks where the passing window opens and closes. From that window it computes a centre phase and treats the candidate set as circular, so a window may wrap past the last index.

During the sweep the controller holds a delay-loop mode output low, and it restores that output when the sweep ends. It pulses an interrupt-status clear before every trial and once more when the sweep finishes. When at least one trial passed, the centre phase becomes the stored phase that drives the sample clock. When none passed, the controller raises an error flag and keeps the phase it had before.

Top module: `sample_phase_tuner`

## Requirements
- R1: After synchronous reset, `phaseSel` is 0, `dllMode` is 1, and `busy`, `done`, `tuneErr`, `trialReq` and `intClr` are all 0. Raise and fall trackers are invalid.
- R2: Trials run in ascending phase index order starting at 0. While `trialReq` is high, `phaseSel` equals the index of the trial in progress.
- R3: `intClr` pulses for one cycle before each trial and once more when the sweep ends, so a sweep of N trials gives N+1 pulses. `intClrMask` is all 17 bits set during a pulse and zero otherwise.
- R4: A trial fails when `trialErr` or `edgeFound` is 1 in the cycle that `trialDone` is sampled. Otherwise it passes.
- R5: For trial index i > 0, a pass at i-1 followed by a fail at i records a fall point of i-1, and a fail at i-1 followed by a pass at i records a raise point of i. The sweep stops after the trial in which both points are recorded. Otherwise it ends after the last index.
- R6: `dllMode` is 0 from the first clear pulse through the last trial, and it is 1 again in the cycle after the final trial completes, whether or not tuning succeeded.
- R7: If no trial passed, `tuneErr` is 1 after the sweep and `phaseSel` keeps its value from before the sweep.
- R8: When some trial passed, a missing raise point is taken as 0 and a missing fall point as the last index (7 for eight phases).
- R9: With raise r and fall f, the result is (r+f)/2 if f >= r. If f < r and r+f exceeds the last index, the result is f/2. If f < r otherwise, the result is (r+last)/2. All divisions truncate. The result drives `phaseSel` after the sweep.
- R10: `done` is a one-cycle pulse issued with `busy` low, and `phaseSel` and `tuneErr` hold until the next start. A `start` while `busy` is high has no effect.
- R11: `trialReq` stays high until `trialDone` is sampled high, and `trialDone` outside a request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a tuning sweep (taken only when idle) |
| trialDone | input | 1 | Command engine finished the requested trial |
| trialErr | input | 1 | Trial command reported an error |
| edgeFound | input | 1 | Sampler saw a data edge during the trial |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when the sweep result is ready |
| trialReq | output | 1 | Request one tuning trial at the current phase |
| phaseSel | output | 3 | Sample phase index applied to the clock phase shifter |
| tuneErr | output | 1 | Last sweep found no passing phase |
| dllMode | output | 1 | Delay-loop mode control, low while sweeping |
| intClr | output | 1 | Interrupt-status clear strobe |
| intClrMask | output | 17 | Bits to clear, all ones with the strobe |

## Verification
The sweep is driven with pass/fail patterns that are chosen so each result comes from a different branch of the centre rule. An all-pass pattern exercises both default points. Windows with only one edge exercise each default on its own. A plain interior window gives f >= r. Two wrapped windows, one whose edge sum exceeds the last index and one whose sum does not, separate the two circular branches. A pattern with a single passing phase shows the early stop through its trial count. Patterns where only the edge flag, or a mix of error and edge flag, makes trials fail show that both inputs count as failure. All-fail runs show that the stored phase survives an unsuccessful sweep. Further runs poke `start` mid-sweep and `trialDone` while idle, and apply reset mid-sweep.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_REQ,
    ST_EVAL,
    ST_FINISH
  } tuneState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sweepInit;  // start of sweep: reset trackers and index
    logic record;     // trial result valid this cycle
    logic stepIdx;    // move to next phase index
    logic commit;     // end of sweep: latch result
  } tuneStrobe_t;

endpackage

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        trialDone,
  input  logic        bothEdges,
  input  logic        lastIdx,
  output tuneStrobe_t strobe,
  output logic        busy,
  output logic        sweeping,
  output logic        trialReq,
  output logic        intClr
);

  tuneState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    trialReq  = 1'b0;
    intClr    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.sweepInit = 1'b1;
          nextState        = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        intClr    = 1'b1;
        nextState = ST_REQ;
      end
      ST_REQ: begin
        trialReq = 1'b1;
        if (trialDone) begin
          strobe.record = 1'b1;
          nextState     = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (bothEdges || lastIdx) begin
          nextState = ST_FINISH;
        end else begin
          strobe.stepIdx = 1'b1;
          nextState      = ST_CLEAR;
        end
      end
      ST_FINISH: begin
        intClr        = 1'b1;
        strobe.commit = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign sweeping = (state == ST_CLEAR) || (state == ST_REQ) || (state == ST_EVAL);

endmodule

// File: rtl/tune_dp.sv
module tune_dp
  import tune_pkg::*;
#(
  parameter  int NUM_PHASES = 8,
  localparam int PW         = $clog2(NUM_PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  input  tuneStrobe_t   strobe,
  input  logic          sweeping,
  input  logic          trialErr,
  input  logic          edgeFound,
  output logic [PW-1:0] phaseSel,
  output logic          tuneErr,
  output logic          done,
  output logic          bothEdges,
  output logic          lastIdx
);

  localparam logic [PW-1:0] LAST_IDX = PW'(NUM_PHASES - 1);
  localparam logic [PW:0]   LAST_W   = (PW + 1)'(NUM_PHASES - 1);

  logic [PW-1:0] idx, raisePt, fallPt, tunedPhase, midPhase;
  logic          raiseOk, fallOk, prevBad, found, tuneErrQ, doneQ;
  logic          trialBad;
  logic [PW:0]   rSel, fSel, sumRF, midW;

  assign trialBad = trialErr | edgeFound;

  // centre of window, phases treated as circular
  always_comb begin
    rSel  = raiseOk ? {1'b0, raisePt} : '0;
    fSel  = fallOk  ? {1'b0, fallPt}  : LAST_W;
    sumRF = rSel + fSel;
    if (fSel >= rSel)        midW = sumRF >> 1;
    else if (sumRF > LAST_W) midW = fSel >> 1;
    else                     midW = (rSel + LAST_W) >> 1;
    midPhase = midW[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      raisePt    <= '0;
      fallPt     <= '0;
      raiseOk    <= 1'b0;
      fallOk     <= 1'b0;
      prevBad    <= 1'b0;
      found      <= 1'b0;
      tunedPhase <= '0;
      tuneErrQ   <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= strobe.commit;
      if (strobe.sweepInit) begin
        idx      <= '0;
        raiseOk  <= 1'b0;
        fallOk   <= 1'b0;
        prevBad  <= 1'b0;
        found    <= 1'b0;
        tuneErrQ <= 1'b0;
      end
      if (strobe.record) begin
        if (idx != '0) begin
          if (trialBad && !prevBad) begin
            fallPt <= idx - PW'(1);
            fallOk <= 1'b1;
          end
          if (!trialBad && prevBad) begin
            raisePt <= idx;
            raiseOk <= 1'b1;
          end
        end
        prevBad <= trialBad;
        if (!trialBad) found <= 1'b1;
      end
      if (strobe.stepIdx) idx <= idx + PW'(1);
      if (strobe.commit) begin
        tuneErrQ <= !found;
        if (found) tunedPhase <= midPhase;
      end
    end
  end

  assign phaseSel  = sweeping ? idx : tunedPhase;
  assign tuneErr   = tuneErrQ;
  assign done      = doneQ;
  assign bothEdges = raiseOk & fallOk;
  assign lastIdx   = (idx == LAST_IDX);

endmodule

// File: rtl/sample_phase_tuner.sv
module sample_phase_tuner
  import tune_pkg::*;
#(
  parameter int NUM_PHASES = 8,
  parameter int CLR_W      = 17
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          trialDone,
  input  logic                          trialErr,
  input  logic                          edgeFound,
  output logic                          busy,
  output logic                          done,
  output logic                          trialReq,
  output logic [$clog2(NUM_PHASES)-1:0] phaseSel,
  output logic                          tuneErr,
  output logic                          dllMode,
  output logic                          intClr,
  output logic [CLR_W-1:0]              intClrMask
);

  tuneStrobe_t strobe;
  logic        sweeping, bothEdges, lastIdx;

  tune_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .trialDone (trialDone),
    .bothEdges (bothEdges),
    .lastIdx   (lastIdx),
    .strobe    (strobe),
    .busy      (busy),
    .sweeping  (sweeping),
    .trialReq  (trialReq),
    .intClr    (intClr)
  );

  tune_dp #(.NUM_PHASES(NUM_PHASES)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .sweeping  (sweeping),
    .trialErr  (trialErr),
    .edgeFound (edgeFound),
    .phaseSel  (phaseSel),
    .tuneErr   (tuneErr),
    .done      (done),
    .bothEdges (bothEdges),
    .lastIdx   (lastIdx)
  );

  assign dllMode    = !sweeping;
  assign intClrMask = {CLR_W{intClr}};

endmodule

// File: rtl/sample_phase_tuner_chk.sv
module sample_phase_tuner_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          trialReq,
  input logic          trialDone,
  input logic          intClr,
  input logic          dllMode,
  input logic [PW-1:0] phaseSel
);

  a_r3_clear_before_trial: assert property (@(posedge clk) disable iff (rst)
    $rose(trialReq) |-> $past(intClr));

  a_r6_dll_low_in_trial: assert property (@(posedge clk) disable iff (rst)
    trialReq |-> !dllMode);

  a_r6_dll_high_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> dllMode);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    (trialReq && !trialDone) |=> trialReq);

  a_r2_phase_steady_in_trial: assert property (@(posedge clk) disable iff (rst)
    (trialReq && $past(trialReq)) |-> $stable(phaseSel));

endmodule

bind sample_phase_tuner sample_phase_tuner_chk #(.PW($clog2(NUM_PHASES))) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .trialReq  (trialReq),
  .trialDone (trialDone),
  .intClr    (intClr),
  .dllMode   (dllMode),
  .phaseSel  (phaseSel)
);

// File: tb/sample_phase_tuner_bench.sv
`timescale 1ns/1ps
module sample_phase_tuner_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        trialDone = 1'b0;
  logic        trialErr = 1'b0;
  logic        edgeFound = 1'b0;
  logic        busy, done, trialReq, tuneErr, dllMode, intClr;
  logic [2:0]  phaseSel;
  logic [16:0] intClrMask;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sample_phase_tuner u_sample_phase_tuner (
    .clk(clk), .rst(rst), .start(start), .trialDone(trialDone),
    .trialErr(trialErr), .edgeFound(edgeFound), .busy(busy), .done(done),
    .trialReq(trialReq), .phaseSel(phaseSel), .tuneErr(tuneErr),
    .dllMode(dllMode), .intClr(intClr), .intClrMask(intClrMask)
  );

  typedef struct packed {
    logic [7:0] em;   // trialErr per phase
    logic [7:0] ed;   // edgeFound per phase
    logic [2:0] ph;   // expected phaseSel after sweep
    logic       err;  // expected tuneErr
    logic [3:0] n;    // expected trial count
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{em:8'h00, ed:8'h00, ph:3'd3, err:1'b0, n:4'd8},  // R8 both defaults
    '{em:8'h87, ed:8'h00, ph:3'd4, err:1'b0, n:4'd8},  // R5 interior window
    '{em:8'h3C, ed:8'h00, ph:3'd6, err:1'b0, n:4'd7},  // R9 wrap, sum <= last
    '{em:8'h78, ed:8'h00, ph:3'd1, err:1'b0, n:4'd8},  // R9 wrap, sum > last
    '{em:8'hE0, ed:8'h00, ph:3'd2, err:1'b0, n:4'd8},  // R8 raise default
    '{em:8'h1F, ed:8'h00, ph:3'd6, err:1'b0, n:4'd8},  // R8 fall default
    '{em:8'h03, ed:8'h84, ph:3'd4, err:1'b0, n:4'd8},  // R4 mixed error and edge flag
    '{em:8'hFD, ed:8'h00, ph:3'd1, err:1'b0, n:4'd3},  // R5 early stop
    '{em:8'hFF, ed:8'h00, ph:3'd1, err:1'b1, n:4'd8},  // R7 all fail
    '{em:8'h00, ed:8'hFF, ph:3'd1, err:1'b1, n:4'd8}   // R4 R7 edge only
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runSweep(input logic [7:0] em, input logic [7:0] ed, input bit poke,
                          output int trials, output int clrs, output bit sawDone);
    bit poked = 0;
    trials = 0; clrs = 0; sawDone = 0;
    start = 1'b1;
    @(negedge clk);
    for (int cyc = 0; cyc < 400; cyc++) begin
      start = 1'b0;
      if (poke && !poked && trials == 3) begin start = 1'b1; poked = 1; end
      if (intClr) begin
        clrs++;
        chk(intClrMask == 17'h1FFFF, "R3 mask", int'(intClrMask), 17'h1FFFF);
      end else if (intClrMask != '0) begin
        chk(1'b0, "R3 mask idle", int'(intClrMask), 0);
      end
      if (done) begin sawDone = 1; break; end
      if (trialReq && !trialDone) begin
        chk(phaseSel == 3'(trials), "R2 trial order", phaseSel, trials);
        chk(dllMode == 1'b0, "R6 dll low", dllMode, 0);
        trialDone = 1'b1;
        trialErr  = (trials < 8) ? em[trials] : 1'b0;
        edgeFound = (trials < 8) ? ed[trials] : 1'b0;
        trials++;
      end else begin
        trialDone = 1'b0; trialErr = 1'b0; edgeFound = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; trialDone = 1'b0; trialErr = 1'b0; edgeFound = 1'b0;
  endtask

  task automatic checkResult(input vec_t v, input int trials, input int clrs, input bit sawDone);
    chk(sawDone, "R10 done seen", sawDone, 1);
    chk(trials == int'(v.n), "R5 trial count", trials, v.n);
    chk(clrs == int'(v.n) + 1, "R3 clear count", clrs, v.n + 1);
    chk(phaseSel == v.ph, "R9 phase", phaseSel, v.ph);
    chk(tuneErr == v.err, "R7 tuneErr", tuneErr, v.err);
    chk(busy == 1'b0, "R10 busy with done", busy, 0);
    chk(dllMode == 1'b1, "R6 dll restored", dllMode, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done pulse", done, 0);
    chk(phaseSel == v.ph, "R10 phase held", phaseSel, v.ph);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int trials, clrs;
    bit sawDone;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(phaseSel == 3'd0, "R1 phaseSel", phaseSel, 0);
    chk(dllMode == 1'b1, "R1 dllMode", dllMode, 1);
    chk(!busy && !done && !tuneErr, "R1 flags", {busy, done, tuneErr}, 0);
    chk(!trialReq && !intClr, "R1 strobes", {trialReq, intClr}, 0);

    for (int i = 0; i < NV; i++) begin
      runSweep(VECS[i].em, VECS[i].ed, 1'b0, trials, clrs, sawDone);
      checkResult(VECS[i], trials, clrs, sawDone);
    end

    // R10 start while busy ignored
    runSweep(8'h87, 8'h00, 1'b1, trials, clrs, sawDone);
    checkResult(VECS[1], trials, clrs, sawDone);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R10 start in sweep ignored", busy, 0);

    // R11 trialDone while idle ignored
    trialDone = 1'b1; trialErr = 1'b1;
    repeat (3) @(negedge clk);
    trialDone = 1'b0; trialErr = 1'b0;
    chk(!busy && !trialReq && !done, "R11 idle trialDone", {busy, trialReq, done}, 0);
    chk(phaseSel == 3'd4, "R11 phase kept", phaseSel, 4);

    // R1 reset mid-sweep
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(dllMode == 1'b0, "R6 dll low in sweep", dllMode, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(phaseSel == 3'd0, "R1 phase after reset", phaseSel, 0);
    chk(dllMode == 1'b1 && !busy, "R1 idle after reset", {dllMode, busy}, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule